// File: doc/BRIEF.md
# Byte/Word Arithmetic Logic Unit with Status Flags

This block is a combinational arithmetic logic unit that works on either 8-bit or 16-bit operands, chosen by a size input. It supports addition, subtraction, bitwise AND, OR and XOR, increment, decrement, one's complement, and single-position shifts left and right. Along with the result it produces six status flags: carry, parity, auxiliary carry, zero, sign and overflow. Flags that an operation must keep are taken from a flag input.

A datapath drives the operands, the operation code, the size select and the current flag word. It takes the result and the new flags in the same cycle. A compile-time option adds a registered copy of the flag word, which a flag register stage can capture directly.

Operation codes on `op_i`: 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 increment, 6 decrement, 7 complement, 8 shift left, 9 shift right. Codes 10 to 15 are unused. Flag word bit positions in `flags_i`, `flags_o` and `flags_r_o` are: bit 0 carry, bit 1 parity, bit 2 auxiliary carry, bit 3 zero, bit 4 sign, bit 5 overflow.

Top module: `bwalu_top`

## Requirements
- R1: Add (code 0) returns a+b and subtract (code 1) returns a−b, both modulo the operand size. Carry (bit 0) is the carry out of the top operand bit for add and the borrow for subtract.
- R2: When `word_i`=0, only `a_i[7:0]` and `b_i[7:0]` are used and `res_o[15:8]` is 0. Carry, zero, sign and overflow then refer to bit 7 and the low byte.
- R3: Overflow (bit 5) is set for add, subtract, increment and decrement when the signed result does not fit the operand size. This is 8 bits in byte mode and 16 bits in word mode.
- R4: Auxiliary carry (bit 2) is the carry out of, or the borrow into, bit 3 for add, subtract, increment and decrement, in both sizes.
- R5: Parity (bit 1) is 1 when `res_o[7:0]` holds an even number of ones, in both sizes, for every operation that updates flags.
- R6: Zero (bit 3) is 1 when the size-wide result is 0. Sign (bit 4) equals the top bit of the size-wide result.
- R7: AND, OR and XOR (codes 2–4) clear carry, overflow and auxiliary carry.
- R8: Increment and decrement (codes 5, 6) return a+1 and a−1 and copy the carry flag from `flags_i[0]`.
- R9: Complement (code 7) returns ~a within the operand size and sets `flags_o` equal to `flags_i`.
- R10: Shift left (code 8) fills with 0 and moves the old top bit into carry; overflow = carry XOR the new top bit. Shift right (code 9) fills with 0 and moves the old bit 0 into carry; overflow = the old top bit. Both clear auxiliary carry.
- R11: Codes 10–15 return 0 and set `flags_o` equal to `flags_i`.
- R12: With REG_FLAGS=1, `flags_r_o` shows the `flags_o` value of the previous clock edge and is 0 while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered flag copy |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_i | input | 4 | Operation code |
| word_i | input | 1 | 1 = 16-bit operation, 0 = 8-bit operation |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| flags_i | input | 6 | Current flag word, source of preserved flags |
| res_o | output | 16 | Result |
| flags_o | output | 6 | New flag word, combinational |
| flags_r_o | output | 6 | Registered flag word |

## Verification
A bad carry or borrow term inside the adder shows in `res_o` and in carry, auxiliary carry or overflow on the same vector. It most often appears at the size boundaries: 0x7F/0xFF in byte mode and 0x7FFF/0xFFFF in word mode. A size-select mistake leaks upper bits into a byte result or takes flags from the wrong bit, and the byte-mode vectors, which carry junk in their upper operand bits, expose it at once. A stale or mistimed flag register shows one clock later, as a mismatch between `flags_r_o` and the flags of the previous vector.

// File: rtl/bwalu_pkg.sv
`timescale 1ns/1ps
package bwalu_pkg;
    localparam int DATA_W = 16;
    localparam int BYTE_W = 8;
    localparam int OP_W   = 4;
    localparam int FLAG_W = 6;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_AND = 4'd2,
        OP_OR  = 4'd3,
        OP_XOR = 4'd4,
        OP_INC = 4'd5,
        OP_DEC = 4'd6,
        OP_NOT = 4'd7,
        OP_SHL = 4'd8,
        OP_SHR = 4'd9
    } op_e;

    // bit 0 carry ... bit 5 overflow (packed: first field is the MSB)
    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zro;
        logic aux;
        logic par;
        logic cry;
    } flags_t;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        flags_t            flg;
    } alu_out_t;
endpackage

// File: rtl/bwalu_addsub.sv
`timescale 1ns/1ps
module bwalu_addsub
    import bwalu_pkg::*;
(
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    input  logic              word,
    output logic [DATA_W-1:0] res,
    output logic              cry,
    output logic              aux,
    output logic              ovf
);
    localparam int TOP_W = DATA_W - 1;
    localparam int TOP_B = BYTE_W - 1;

    logic [DATA_W:0]   ext;
    logic [DATA_W-1:0] carries;
    logic              a_top, b_top, r_top;

    always_comb begin
        if (sub) ext = {1'b0, a} - {1'b0, b};
        else     ext = {1'b0, a} + {1'b0, b};
        carries = a ^ b ^ ext[DATA_W-1:0];
        aux     = carries[4];
        if (word) begin
            res   = ext[DATA_W-1:0];
            cry   = ext[DATA_W];
            a_top = a[TOP_W];
            b_top = b[TOP_W];
            r_top = ext[TOP_W];
        end else begin
            res   = {{(DATA_W-BYTE_W){1'b0}}, ext[BYTE_W-1:0]};
            cry   = ext[BYTE_W];
            a_top = a[TOP_B];
            b_top = b[TOP_B];
            r_top = ext[TOP_B];
        end
        if (sub) ovf = (a_top != b_top) && (r_top != a_top);
        else     ovf = (a_top == b_top) && (r_top != a_top);
    end
endmodule

// File: rtl/bwalu_bitops.sv
`timescale 1ns/1ps
module bwalu_bitops
    import bwalu_pkg::*;
(
    input  op_e               op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              word,
    output logic [DATA_W-1:0] res,
    output logic              cry,
    output logic              ovf
);
    localparam int TOP_W = DATA_W - 1;
    localparam int TOP_B = BYTE_W - 1;

    logic [DATA_W-1:0] raw;
    logic [DATA_W-1:0] mask;
    logic              a_top;

    always_comb begin
        mask  = word ? {DATA_W{1'b1}} : {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
        a_top = word ? a[TOP_W] : a[TOP_B];
        cry   = 1'b0;
        ovf   = 1'b0;
        case (op)
            OP_AND:  raw = a & b;
            OP_OR:   raw = a | b;
            OP_XOR:  raw = a ^ b;
            OP_NOT:  raw = ~a;
            OP_SHL: begin
                raw = {a[DATA_W-2:0], 1'b0};
                cry = a_top;
            end
            OP_SHR: begin
                raw = {1'b0, a[DATA_W-1:1]};
                cry = a[0];
                ovf = a_top;
            end
            default: raw = '0;
        endcase
        res = raw & mask;
        if (op == OP_SHL) ovf = cry ^ (word ? res[TOP_W] : res[TOP_B]);
    end
endmodule

// File: rtl/bwalu_resflags.sv
`timescale 1ns/1ps
module bwalu_resflags
    import bwalu_pkg::*;
(
    input  logic [DATA_W-1:0] res,
    input  logic              word,
    output logic              zro,
    output logic              sgn,
    output logic              par
);
    always_comb begin
        par = ~^res[BYTE_W-1:0];
        if (word) begin
            zro = (res == '0);
            sgn = res[DATA_W-1];
        end else begin
            zro = (res[BYTE_W-1:0] == '0);
            sgn = res[BYTE_W-1];
        end
    end
endmodule

// File: rtl/bwalu_top.sv
`timescale 1ns/1ps
module bwalu_top
    import bwalu_pkg::*;
#(
    parameter bit REG_FLAGS = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   op_i,
    input  logic              word_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic [DATA_W-1:0] res_o,
    output logic [FLAG_W-1:0] flags_o,
    output logic [FLAG_W-1:0] flags_r_o
);
    op_e               op;
    logic [DATA_W-1:0] a_m, b_m, as_b;
    logic              as_sub;
    logic [DATA_W-1:0] as_res, bo_res;
    logic              as_cry, as_aux, as_ovf, bo_cry, bo_ovf;
    logic              rf_zro, rf_sgn, rf_par;
    flags_t            fin;
    alu_out_t          out_d;

    assign op   = op_e'(op_i);
    assign fin  = flags_t'(flags_i);
    assign a_m  = word_i ? a_i : {{(DATA_W-BYTE_W){1'b0}}, a_i[BYTE_W-1:0]};
    assign b_m  = word_i ? b_i : {{(DATA_W-BYTE_W){1'b0}}, b_i[BYTE_W-1:0]};
    assign as_b = (op == OP_INC || op == OP_DEC) ? DATA_W'(1) : b_m;
    assign as_sub = (op == OP_SUB || op == OP_DEC);

    bwalu_addsub u_addsub (
        .a(a_m), .b(as_b), .sub(as_sub), .word(word_i),
        .res(as_res), .cry(as_cry), .aux(as_aux), .ovf(as_ovf)
    );

    bwalu_bitops u_bitops (
        .op(op), .a(a_m), .b(b_m), .word(word_i),
        .res(bo_res), .cry(bo_cry), .ovf(bo_ovf)
    );

    bwalu_resflags u_resflags (
        .res(out_d.res), .word(word_i),
        .zro(rf_zro), .sgn(rf_sgn), .par(rf_par)
    );

    always_comb begin
        out_d.res = '0;
        out_d.flg = fin;
        case (op)
            OP_ADD, OP_SUB, OP_INC, OP_DEC: begin
                out_d.res     = as_res;
                out_d.flg.cry = (op == OP_INC || op == OP_DEC) ? fin.cry : as_cry;
                out_d.flg.aux = as_aux;
                out_d.flg.ovf = as_ovf;
                out_d.flg.zro = rf_zro;
                out_d.flg.sgn = rf_sgn;
                out_d.flg.par = rf_par;
            end
            OP_AND, OP_OR, OP_XOR, OP_SHL, OP_SHR: begin
                out_d.res     = bo_res;
                out_d.flg.cry = bo_cry;
                out_d.flg.aux = 1'b0;
                out_d.flg.ovf = bo_ovf;
                out_d.flg.zro = rf_zro;
                out_d.flg.sgn = rf_sgn;
                out_d.flg.par = rf_par;
            end
            OP_NOT: out_d.res = bo_res;
            default: out_d.res = '0;
        endcase
    end

    assign res_o   = out_d.res;
    assign flags_o = out_d.flg;

    generate
        if (REG_FLAGS) begin : g_reg
            flags_t flags_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) flags_q <= '0;
                else        flags_q <= out_d.flg;
            end
            assign flags_r_o = flags_q;
        end else begin : g_comb
            assign flags_r_o = out_d.flg;
        end
    endgenerate
endmodule

// File: rtl/bwalu_checker.sv
`timescale 1ns/1ps
module bwalu_checker
    import bwalu_pkg::*;
#(
    parameter bit REG_FLAGS = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [OP_W-1:0]   op_i,
    input logic              word_i,
    input logic [DATA_W-1:0] a_i,
    input logic [FLAG_W-1:0] flags_i,
    input logic [DATA_W-1:0] res_o,
    input logic [FLAG_W-1:0] flags_o,
    input logic [FLAG_W-1:0] flags_r_o
);
    logic updates;
    assign updates = (op_i <= 4'd9) && (op_i != 4'd7);

    // R2
    p_byte_upper_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !word_i |-> res_o[DATA_W-1:BYTE_W] == '0);
    // R5
    p_parity_low_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
        updates |-> flags_o[1] == ~^res_o[BYTE_W-1:0]);
    // R6
    p_zero_matches_r6: assert property (@(posedge clk) disable iff (!rst_n)
        updates |-> flags_o[3] == (word_i ? (res_o == '0) : (res_o[BYTE_W-1:0] == '0)));
    // R7
    p_logic_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i >= 4'd2 && op_i <= 4'd4) |-> (flags_o[0] == 1'b0 && flags_o[5] == 1'b0 && flags_o[2] == 1'b0));
    // R8
    p_incdec_carry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd5 || op_i == 4'd6) |-> flags_o[0] == flags_i[0]);
    // R9
    p_not_keeps_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd7) |-> flags_o == flags_i);
    // R10
    p_shr_carry_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd9) |-> flags_o[0] == a_i[0]);
    // R11
    p_unused_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i > 4'd9) |-> (res_o == '0 && flags_o == flags_i));

    generate
        if (REG_FLAGS) begin : g_reg_chk
            // R12
            p_reg_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> flags_r_o == $past(flags_o));
        end
    endgenerate
endmodule

bind bwalu_top bwalu_checker #(.REG_FLAGS(REG_FLAGS)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .word_i(word_i), .a_i(a_i),
    .flags_i(flags_i), .res_o(res_o), .flags_o(flags_o), .flags_r_o(flags_r_o)
);

// File: tb/bwalu_top_bench.sv
`timescale 1ns/1ps
module bwalu_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_i = '0;
    logic        word_i = 1'b0;
    logic [15:0] a_i = '0;
    logic [15:0] b_i = '0;
    logic [5:0]  flags_i = '0;
    logic [15:0] res_o;
    logic [5:0]  flags_o;
    logic [5:0]  flags_r_o;

    int   n_vec = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;
    bit   have_prev = 1'b0;
    logic [5:0] prev_flags;
    string prev_tag;

    always #2 clk = ~clk;   // 250 MHz

    bwalu_top u_bwalu_top (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .word_i(word_i),
        .a_i(a_i), .b_i(b_i), .flags_i(flags_i),
        .res_o(res_o), .flags_o(flags_o), .flags_r_o(flags_r_o)
    );

    // behavioural reference: returns {flags[5:0], result[15:0]}
    function automatic logic [21:0] model(input int op, input bit w,
                                          input int a, input int b, input logic [5:0] fin);
        int m, half, ua, ub, sa, sb, full, r, s, cnt, top;
        bit c, ac, v, z, sg, p, keep;
        m    = w ? 65535 : 255;
        half = (m + 1) / 2;
        top  = w ? 15 : 7;
        ua   = a & m;
        ub   = b & m;
        if (op == 5 || op == 6) ub = 1;
        sa   = (ua >= half) ? ua - (m + 1) : ua;
        sb   = (ub >= half) ? ub - (m + 1) : ub;
        c = 0; ac = 0; v = 0; r = 0; keep = 0;
        case (op)
            0, 5: begin
                full = ua + ub; r = full & m; c = (full > m);
                ac = ((ua & 15) + (ub & 15)) > 15;
                s = sa + sb; v = (s > half - 1) || (s < -half);
                if (op == 5) c = fin[0];
            end
            1, 6: begin
                full = ua - ub; r = full & m; c = (ua < ub);
                ac = (ua & 15) < (ub & 15);
                s = sa - sb; v = (s > half - 1) || (s < -half);
                if (op == 6) c = fin[0];
            end
            2: r = ua & ub;
            3: r = ua | ub;
            4: r = ua ^ ub;
            7: begin r = (~ua) & m; keep = 1; end
            8: begin r = (ua << 1) & m; c = ((ua >> top) & 1) != 0; v = c ^ (((r >> top) & 1) != 0); end
            9: begin r = ua >> 1; c = (ua & 1) != 0; v = ((ua >> top) & 1) != 0; end
            default: begin r = 0; keep = 1; end
        endcase
        z = (r == 0);
        sg = ((r >> top) & 1) != 0;
        cnt = 0;
        for (int i = 0; i < 8; i++) cnt += (r >> i) & 1;
        p = (cnt % 2) == 0;
        if (keep) return {fin, r[15:0]};
        return {v, sg, z, ac, p, c, r[15:0]};
    endfunction

    function automatic string req_of(input int op);
        case (op)
            0, 1: return "R1";
            2, 3, 4: return "R7";
            5, 6: return "R8";
            7: return "R9";
            8, 9: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic apply(input int op, input bit w, input int a, input int b,
                         input logic [5:0] fin, input string tag);
        logic [21:0] exp;
        @(negedge clk);
        if (have_prev) begin
            n_vec++;
            if (flags_r_o !== prev_flags) begin
                n_bad++;
                $display("FAIL R12 registered flags after %s: got %b exp %b", prev_tag, flags_r_o, prev_flags);
            end
        end
        op_i = op[3:0]; word_i = w; a_i = a[15:0]; b_i = b[15:0]; flags_i = fin;
        #1;
        exp = model(op, w, a, b, fin);
        n_vec++;
        if (res_o !== exp[15:0] || flags_o !== exp[21:16]) begin
            n_bad++;
            $display("FAIL %s op=%0d w=%0d a=%h b=%h: got res=%h flags=%b exp res=%h flags=%b",
                     tag, op, w, a[15:0], b[15:0], res_o, flags_o, exp[15:0], exp[21:16]);
        end
        prev_flags = exp[21:16];
        prev_tag   = tag;
        have_prev  = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // R12: register cleared during reset even with active inputs
        op_i = 4'd0; word_i = 1'b1; a_i = 16'hFFFF; b_i = 16'h0001; flags_i = 6'h3F;
        repeat (3) @(negedge clk);
        n_vec++;
        if (flags_r_o !== 6'd0) begin
            n_bad++;
            $display("FAIL R12 reset value: got %b exp %b", flags_r_o, 6'd0);
        end
        rst_n = 1'b1;

        // R1 carry / borrow
        apply(0, 1, 16'hFFFF, 16'h0001, 6'h00, "R1 word carry wrap");
        apply(1, 1, 16'h0000, 16'h0001, 6'h00, "R1 word borrow");
        apply(0, 1, 16'h1234, 16'h4321, 6'h3F, "R1 word plain add");
        // R2 byte mode with junk in upper bits
        apply(0, 0, 16'hAAFF, 16'h5501, 6'h00, "R2 byte carry, upper ignored");
        apply(1, 0, 16'hFF10, 16'h0020, 6'h00, "R2 byte borrow");
        apply(4, 0, 16'hF0F0, 16'h0F0F, 6'h3F, "R2 byte xor upper cleared");
        // R3 overflow
        apply(0, 1, 16'h7FFF, 16'h0001, 6'h00, "R3 word positive overflow");
        apply(0, 0, 16'h007F, 16'h0001, 6'h00, "R3 byte positive overflow");
        apply(1, 0, 16'h0080, 16'h0001, 6'h00, "R3 byte negative overflow");
        apply(1, 1, 16'h8000, 16'h0001, 6'h00, "R3 word negative overflow");
        apply(0, 1, 16'h0080, 16'h0080, 6'h00, "R3 word no overflow at byte edge");
        // R4 aux carry
        apply(0, 1, 16'h000F, 16'h0001, 6'h00, "R4 aux carry add");
        apply(1, 0, 16'h0010, 16'h0001, 6'h00, "R4 aux borrow sub");
        apply(5, 1, 16'h00FF, 16'h0000, 6'h00, "R4 aux on increment");
        // R5 parity from low byte only
        apply(0, 1, 16'h0100, 16'h0200, 6'h00, "R5 parity low byte zero");
        apply(3, 1, 16'h0700, 16'h0001, 6'h00, "R5 parity odd low byte");
        // R6 zero and sign
        apply(1, 1, 16'h8001, 16'h8001, 6'h00, "R6 word zero");
        apply(0, 0, 16'h1280, 16'h0000, 6'h00, "R6 byte sign");
        apply(0, 0, 16'hFF00, 16'h0100, 6'h00, "R6 byte zero despite upper bits");
        // R7 logic clears
        apply(2, 1, 16'hFFFF, 16'h8000, 6'h3F, "R7 and clears carry/ovf/aux");
        // R8 inc/dec keep carry
        apply(5, 1, 16'hFFFF, 16'h0000, 6'h00, "R8 inc wrap keeps carry 0");
        apply(6, 1, 16'h0000, 16'h0000, 6'h01, "R8 dec wrap keeps carry 1");
        apply(6, 0, 16'h0080, 16'h0000, 6'h00, "R8 dec byte overflow");
        // R9 complement
        apply(7, 1, 16'h00FF, 16'h0000, 6'b101010, "R9 complement word flags held");
        apply(7, 0, 16'h1234, 16'h0000, 6'b010101, "R9 complement byte flags held");
        // R10 shifts
        apply(8, 1, 16'h8000, 16'h0000, 6'h00, "R10 shl word carry out");
        apply(8, 0, 16'h0040, 16'h0000, 6'h00, "R10 shl byte overflow");
        apply(9, 1, 16'h0001, 16'h0000, 6'h00, "R10 shr carry out");
        apply(9, 0, 16'hFF81, 16'h0000, 6'h00, "R10 shr byte overflow from top");
        // R11 unused codes
        apply(12, 1, 16'hABCD, 16'h1111, 6'b110011, "R11 unused code");
        apply(15, 0, 16'hFFFF, 16'hFFFF, 6'b001100, "R11 unused code 15");

        // broad sweep across all codes and both sizes
        for (int k = 0; k < 600; k++) begin
            int op;
            op = k % 16;
            apply(op, k[4], int'($urandom & 32'hFFFF), int'($urandom & 32'hFFFF),
                  6'($urandom), req_of(op));
        end
        @(negedge clk);
        n_vec++;
        if (flags_r_o !== prev_flags) begin
            n_bad++;
            $display("FAIL R12 final registered flags: got %b exp %b", flags_r_o, prev_flags);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule